// File: doc/BRIEF.md
# Serial Word Output with Configurable Word Sync

This block takes parallel words through a valid/ready handshake and sends each one out on a single serial data line. The most significant bit goes first, and one bit goes out for every pulse of a serial clock enable. A programmable word length sets how many low-order bits of each word are sent. Words follow each other with no gap for as long as the next word is already waiting.

Each word carries its own flag that says whether it is marked with a word sync. A marked word produces a sync pulse that lasts exactly one serial period. A static configuration decides where that pulse falls, and the same choice applies to every time slot:

- **Early:** in an extra period just ahead of the first bit.
- **Coincident:** on the first bit itself.
- **Late:** in an extra period just after the last bit.

A polarity setting selects whether the sync is active high or active low. At all other times the sync line rests at its inactive level.

The configuration inputs are meant to change only while reset is asserted.

Top module: `wordsync_serializer`

## Requirements
- R1: On each clock edge where `sclk_en` is high, the serial output advances one period. The bits of a word are the low `L` bits of `in_word`, sent from bit `L-1` down to bit 0, one bit per period. Outputs never change on edges where `sclk_en` is low.
- R2: The effective word length `L` is `cfg_len`, clamped to the range 4 to 32. A value below 4 acts as 4, and a value above 32 acts as 32.
- R3: With `cfg_pos` = 00 (early), a word whose sync flag is set is preceded by one extra period. In that period sync is active and `ser_data` is 0. The first data bit follows in the next period.
- R4: With `cfg_pos` = 01 (late), a word whose sync flag is set is followed by one extra period. In that period sync is active and `ser_data` is 0. The next word cannot start before the period after it.
- R5: With `cfg_pos` = 10 or 11 (coincident), sync is active during the period of the first data bit of a flagged word, and no extra period is added.
- R6: With `cfg_sync_high` = 1, an active sync drives `ser_sync` to 1; with 0, it drives it to 0. In every other period `ser_sync` sits at the opposite, inactive level, and no sync pulse lasts longer than one period.
- R7: While a word is waiting in the input slot, successive words are sent with no idle period between them. The only periods added are those required by R3 and R4.
- R8: `in_ready` is high exactly when the single input slot is empty. A word is taken on a clock edge where both `in_valid` and `in_ready` are high, and `in_ready` is low in the cycle that follows.
- R9: When no word is being sent and none is waiting, `ser_data` is 0 and `ser_sync` is inactive.
- R10: During reset, `in_ready` is 1, `ser_data` is 0 and `ser_sync` is at the inactive level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_en | input | 1 | Serial clock enable, one pulse per serial period |
| cfg_pos | input | 2 | Sync position: 00 early, 01 late, 1x coincident |
| cfg_sync_high | input | 1 | 1 = active-high sync, 0 = active-low sync |
| cfg_len | input | 6 | Word length in bits, clamped to 4..32 |
| in_word | input | 32 | Parallel word to send |
| in_sync | input | 1 | Sync flag for this word |
| in_valid | input | 1 | Word and flag are valid |
| in_ready | output | 1 | Input slot is empty |
| ser_data | output | 1 | Serial data, MSB first |
| ser_sync | output | 1 | Word sync |

## Verification
The hardest situation to reach is the boundary between words. A late sync period, or an early sync period, has to sit exactly between the last bit of one word and the first bit of the next, with no stray idle period. That only happens when the next word has already been accepted before the current word ends.

The stimulus keeps the input slot refilled right after every take, and spaces the serial enables two to five clocks apart. This produces long back-to-back streams, including runs where every word is flagged, at word lengths of 4, 32, clamped values and random values. Each recorded serial period is compared against a stream computed by the bench for every position code and both polarities.

// File: rtl/wsync_pkg.sv
package wsync_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_PRE  = 2'b01,
    ST_DATA = 2'b10,
    ST_POST = 2'b11
  } wsync_state_e;

  localparam logic [1:0] POS_EARLY = 2'b00;
  localparam logic [1:0] POS_LATE  = 2'b01;
endpackage

// File: rtl/wsync_hold.sv
module wsync_hold #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] in_word,
  input  logic         in_sync,
  input  logic         pop,
  output logic         in_ready,
  output logic         hold_valid,
  output logic [W-1:0] hold_word,
  output logic         hold_sync
);
  logic         vld_q, vld_n;
  logic [W-1:0] word_q, word_n;
  logic         sync_q, sync_n;
  logic         accept;

  assign in_ready = !vld_q;
  assign accept   = in_valid && !vld_q;

  always_comb begin
    vld_n  = vld_q;
    word_n = word_q;
    sync_n = sync_q;
    if (accept) begin
      vld_n  = 1'b1;
      word_n = in_word;
      sync_n = in_sync;
    end else if (pop) begin
      vld_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      word_q <= '0;
      sync_q <= 1'b0;
    end else begin
      vld_q  <= vld_n;
      word_q <= word_n;
      sync_q <= sync_n;
    end
  end

  assign hold_valid = vld_q;
  assign hold_word  = word_q;
  assign hold_sync  = sync_q;
endmodule

// File: rtl/wsync_shifter.sv
module wsync_shifter #(
  parameter int W  = 32,
  parameter int LW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          shift,
  input  logic [W-1:0]  word_in,
  input  logic [LW-1:0] len_in,
  output logic          msb,
  output logic          last
);
  localparam logic [LW-1:0] W_L = LW'(W);

  logic [W-1:0]  sh_q, sh_n;
  logic [LW-1:0] cnt_q, cnt_n;
  logic [LW-1:0] shamt;

  assign shamt = W_L - len_in;

  always_comb begin
    sh_n  = sh_q;
    cnt_n = cnt_q;
    if (load) begin
      sh_n  = word_in << shamt;
      cnt_n = len_in;
    end else if (shift) begin
      sh_n  = sh_q << 1;
      cnt_n = cnt_q - LW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else begin
      sh_q  <= sh_n;
      cnt_q <= cnt_n;
    end
  end

  assign msb  = sh_q[W-1];
  assign last = (cnt_q == LW'(1));
endmodule

// File: rtl/wsync_seq.sv
module wsync_seq
  import wsync_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [1:0]   pos,
  input  logic         hold_valid,
  input  logic         hold_sync,
  input  logic         sh_last,
  output logic         take,
  output logic         shift,
  output wsync_state_e state,
  output logic         sync_now
);
  wsync_state_e st_q, st_n;
  logic         cur_q, cur_n;
  logic         sy_q, sy_n;

  always_comb begin
    st_n  = st_q;
    cur_n = cur_q;
    sy_n  = sy_q;
    take  = 1'b0;
    shift = 1'b0;
    if (en) begin
      if (st_q == ST_PRE) begin
        st_n = ST_DATA;
        sy_n = 1'b0;
      end else if (st_q == ST_DATA && !sh_last) begin
        shift = 1'b1;
        sy_n  = 1'b0;
      end else if (st_q == ST_DATA && cur_q && pos == POS_LATE) begin
        st_n  = ST_POST;
        sy_n  = 1'b1;
        cur_n = 1'b0;
      end else if (hold_valid) begin
        take  = 1'b1;
        cur_n = hold_sync;
        if (hold_sync && pos == POS_EARLY) begin
          st_n = ST_PRE;
          sy_n = 1'b1;
        end else begin
          st_n = ST_DATA;
          sy_n = hold_sync && pos[1];
        end
      end else begin
        st_n  = ST_IDLE;
        sy_n  = 1'b0;
        cur_n = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cur_q <= 1'b0;
      sy_q  <= 1'b0;
    end else begin
      st_q  <= st_n;
      cur_q <= cur_n;
      sy_q  <= sy_n;
    end
  end

  assign state    = st_q;
  assign sync_now = sy_q;
endmodule

// File: rtl/wordsync_serializer.sv
module wordsync_serializer
  import wsync_pkg::*;
#(
  parameter  int W       = 32,
  parameter  int MIN_LEN = 4,
  localparam int LW      = $clog2(W + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sclk_en,
  input  logic [1:0]    cfg_pos,
  input  logic          cfg_sync_high,
  input  logic [LW-1:0] cfg_len,
  input  logic [W-1:0]  in_word,
  input  logic          in_sync,
  input  logic          in_valid,
  output logic          in_ready,
  output logic          ser_data,
  output logic          ser_sync
);
  localparam logic [LW-1:0] MIN_L = LW'(MIN_LEN);
  localparam logic [LW-1:0] MAX_L = LW'(W);

  logic [LW-1:0] len_eff;
  logic          hold_valid, hold_sync;
  logic [W-1:0]  hold_word;
  logic          take, shift, sh_msb, sh_last, sync_now;
  wsync_state_e  state;

  always_comb begin
    if (cfg_len < MIN_L)      len_eff = MIN_L;
    else if (cfg_len > MAX_L) len_eff = MAX_L;
    else                      len_eff = cfg_len;
  end

  wsync_hold #(.W(W)) u_hold (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_word    (in_word),
    .in_sync    (in_sync),
    .pop        (take),
    .in_ready   (in_ready),
    .hold_valid (hold_valid),
    .hold_word  (hold_word),
    .hold_sync  (hold_sync)
  );

  wsync_shifter #(.W(W), .LW(LW)) u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (take),
    .shift   (shift),
    .word_in (hold_word),
    .len_in  (len_eff),
    .msb     (sh_msb),
    .last    (sh_last)
  );

  wsync_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (sclk_en),
    .pos        (cfg_pos),
    .hold_valid (hold_valid),
    .hold_sync  (hold_sync),
    .sh_last    (sh_last),
    .take       (take),
    .shift      (shift),
    .state      (state),
    .sync_now   (sync_now)
  );

  assign ser_data = (state == ST_DATA) && sh_msb;
  assign ser_sync = cfg_sync_high ? sync_now : !sync_now;
endmodule

// File: rtl/wsync_checker.sv
module wsync_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       sclk_en,
  input logic [1:0] cfg_pos,
  input logic       cfg_sync_high,
  input logic       in_valid,
  input logic       in_ready,
  input logic       ser_data,
  input logic       ser_sync
);
  logic act;
  assign act = cfg_sync_high ? ser_sync : !ser_sync;

  a_r8_ready_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  a_r1_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
    !sclk_en |=> ($stable(ser_data) && $stable(ser_sync)));

  a_r6_single_period: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_en && act) |=> !act);

  a_r3_early_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (act && cfg_pos == 2'b00) |-> !ser_data);

  a_r4_late_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (act && cfg_pos == 2'b01) |-> !ser_data);
endmodule

bind wordsync_serializer wsync_checker i_wsync_checker (
  .clk           (clk),
  .rst_n         (rst_n),
  .sclk_en       (sclk_en),
  .cfg_pos       (cfg_pos),
  .cfg_sync_high (cfg_sync_high),
  .in_valid      (in_valid),
  .in_ready      (in_ready),
  .ser_data      (ser_data),
  .ser_sync      (ser_sync)
);

// File: tb/test_wordsync_serializer.sv
module test_wordsync_serializer;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        sclk_en;
  logic [1:0]  cfg_pos;
  logic        cfg_sync_high;
  logic [5:0]  cfg_len;
  logic [31:0] in_word;
  logic        in_sync;
  logic        in_valid;
  logic        in_ready;
  logic        ser_data;
  logic        ser_sync;

  int checks = 0;
  int fails  = 0;
  bit exp_d [0:1023];
  bit exp_s [0:1023];
  int exp_n;
  logic [31:0] wval [0:15];
  bit          wsync[0:15];
  bit done = 0;

  always #10 clk = ~clk;

  wordsync_serializer i_wordsync_serializer (
    .clk(clk), .rst_n(rst_n), .sclk_en(sclk_en), .cfg_pos(cfg_pos),
    .cfg_sync_high(cfg_sync_high), .cfg_len(cfg_len), .in_word(in_word),
    .in_sync(in_sync), .in_valid(in_valid), .in_ready(in_ready),
    .ser_data(ser_data), .ser_sync(ser_sync)
  );

  function automatic int eff_len(int l);
    if (l < 4) return 4;
    if (l > 32) return 32;
    return l;
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic push_exp(bit d, bit s);
    exp_d[exp_n] = d;
    exp_s[exp_n] = s;
    exp_n++;
  endtask

  task automatic build_expected(int n, int len, logic [1:0] pos);
    exp_n = 0;
    for (int i = 0; i < n; i++) begin
      if (wsync[i] && pos == 2'b00) push_exp(1'b0, 1'b1);
      for (int j = len - 1; j >= 0; j--)
        push_exp(wval[i][j], wsync[i] && pos[1] && (j == len - 1));
      if (wsync[i] && pos == 2'b01) push_exp(1'b0, 1'b1);
    end
  endtask

  task automatic fill_words(int n, int mode);
    for (int i = 0; i < n; i++) begin
      wval[i]  = $urandom;
      wsync[i] = (mode == 2) ? 1'b1 : (mode == 1) ? 1'b0 : 1'($urandom % 2);
    end
  endtask

  task automatic run_group(string gname, logic [1:0] pos, bit pol, int len,
                           int n, int per, string dreq);
    int  cyc = 0, pushed = 0, rec = 0, idle_seen = 0;
    bit  started = 0, prev_en = 0, prev_valid = 0, prev_ready = 0;
    string sreq;
    sreq = (pos == 2'b00) ? "R3/R6" : (pos == 2'b01) ? "R4/R6" : "R5/R6";
    build_expected(n, eff_len(len), pos);
    @(negedge clk);
    rst_n = 1'b0; sclk_en = 1'b0; in_valid = 1'b0; in_sync = 1'b0; in_word = '0;
    cfg_pos = pos; cfg_sync_high = pol; cfg_len = 6'(len);
    repeat (3) @(negedge clk);
    // R10: reset state
    chk(in_ready == 1'b1, "R10", {gname, " ready in reset"}, in_ready, 1);
    chk(ser_data == 1'b0, "R10", {gname, " data in reset"}, ser_data, 0);
    chk(ser_sync == !pol, "R10", {gname, " sync in reset"}, ser_sync, !pol);
    rst_n = 1'b1;
    while ((rec < exp_n || idle_seen < 3) && cyc < 20000) begin
      @(negedge clk);
      cyc++;
      if (prev_en && started) begin
        if (rec < exp_n) begin
          chk(ser_data == exp_d[rec], dreq, $sformatf("%s period %0d data", gname, rec),
              ser_data, exp_d[rec]);
          chk(ser_sync == (exp_s[rec] ? pol : !pol), sreq,
              $sformatf("%s period %0d sync", gname, rec), ser_sync, exp_s[rec] ? pol : !pol);
          rec++;
        end else begin
          // R9: idle after the stream
          chk(ser_data == 1'b0, "R9", {gname, " idle data"}, ser_data, 0);
          chk(ser_sync == !pol, "R9", {gname, " idle sync"}, ser_sync, !pol);
          idle_seen++;
        end
      end
      if (prev_valid && prev_ready) begin
        started = 1;
        pushed++;
        chk(in_ready == 1'b0, "R8", {gname, " ready after take"}, in_ready, 0);
      end
      sclk_en  = (cyc % per == 0);
      in_valid = (pushed < n);
      if (pushed < n) begin
        in_word = wval[pushed];
        in_sync = wsync[pushed];
      end else begin
        in_word = '0;
        in_sync = 1'b0;
      end
      prev_en    = sclk_en;
      prev_valid = in_valid;
      prev_ready = in_ready;
    end
    chk(rec == exp_n, "R7", {gname, " stream complete"}, rec, exp_n);
    sclk_en  = 1'b0;
    in_valid = 1'b0;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'd24680));
    rst_n = 1'b0; sclk_en = 1'b0; in_valid = 1'b0; in_sync = 1'b0; in_word = '0;
    cfg_pos = 2'b00; cfg_sync_high = 1'b1; cfg_len = 6'd8;

    fill_words(6, 0);  run_group("early_hi_len8",   2'b00, 1'b1,  8, 6, 2, "R1/R7");
    fill_words(6, 0);  run_group("late_lo_len12",   2'b01, 1'b0, 12, 6, 3, "R1/R7");
    fill_words(8, 0);  run_group("coinc10_hi_len4", 2'b10, 1'b1,  4, 8, 2, "R1/R7");
    fill_words(4, 0);  run_group("coinc11_lo_len32",2'b11, 1'b0, 32, 4, 5, "R1/R7");
    fill_words(6, 2);  run_group("clamp_low_3",     2'b00, 1'b0,  3, 6, 2, "R2");
    fill_words(4, 2);  run_group("clamp_high_40",   2'b01, 1'b1, 40, 4, 3, "R2");
    fill_words(6, 1);  run_group("early_nosync",    2'b00, 1'b1,  9, 6, 2, "R1/R7");
    fill_words(10, 2); run_group("late_allsync",    2'b01, 1'b0,  5, 10, 2, "R1/R7");
    fill_words(10, 2); run_group("early_allsync",   2'b00, 1'b1,  4, 10, 2, "R1/R7");
    for (int g = 0; g < 10; g++) begin
      int n = 3 + ($urandom % 8);
      fill_words(n, 0);
      run_group($sformatf("rand%0d", g), 2'($urandom), 1'($urandom),
                4 + ($urandom % 29), n, 2 + ($urandom % 4), "R1/R7");
    end
    done = 1;
    finish_run();
  end
endmodule